// File: doc/BRIEF.md
# Edge-Kicked Watchdog Timer

This block watches a heartbeat line toggled by a processor and drops an active-low fault output when the line has stayed at one level for a full timeout period. Each rising or falling transition of the heartbeat restarts a full countdown. The period is a parameter counted in clock ticks. At a 1 MHz tick the default value gives 1.6 s, and a simulation can pick a much shorter value.

The heartbeat is treated as asynchronous and passes through a synchronizer chain. Three digital inputs clear the timer and keep it cleared: the system reset from the reset generator, a flag saying the heartbeat pin is floating or three-stated, and the block's own register reset. The supply-good flag acts directly on the output. While the supply is low the fault output is forced low with no register in the path. It returns high as soon as the supply recovers, and has no minimum pulse width. Feeding the fault output into a reset generator is done by the system, outside this block.

Top module: `hb_watchdog`

## Requirements
- R1: After `rst_ni` is released, with supply good, `wd_fault_no` is high. A heartbeat level held steady through the release of `rst_ni` does not count as a transition and does not start the timer.
- R2: Until the first transition seen while `sys_rst_i` and `hb_float_i` are both low, the timer stays idle and `wd_fault_no` stays high for any length of time.
- R3: Suppose `hb_i` changes before clock edge A and then holds. With `SYNC_STAGES` = 2 the timer restarts at edge A+2. `wd_fault_no` is still high after edge A+1+`TIMEOUT_TICKS` and goes low after edge A+2+`TIMEOUT_TICKS`.
- R4: A rising transition and a falling transition both restart a full countdown. Transitions spaced closer than the timeout keep `wd_fault_no` high indefinitely.
- R5: While `sys_rst_i` is high, the timer is cleared and does not count. A tripped fault is cleared one clock edge after `sys_rst_i` is seen high. After release, a new transition is needed before counting resumes.
- R6: While `hb_float_i` is high, the timer is cleared and does not count, with the same clearing and restart rules as R5.
- R7: Once `wd_fault_no` is low because of a timeout, it stays low until a transition, `sys_rst_i` or `hb_float_i` clears the timer. The clear by a transition takes effect at edge A+2.
- R8: `wd_fault_no` is low whenever `supply_ok_i` is low. This path has no register. `wd_fault_no` returns to the timer's own value as soon as `supply_ok_i` rises. A supply dip neither clears nor delays the countdown.
- R9: Transitions that reach the timer while it is held cleared (R5, R6) are discarded and do not start the timer once the hold ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer clock; one tick per cycle |
| rst_ni | input | 1 | Asynchronous active-low register reset |
| sys_rst_i | input | 1 | System reset from the reset generator, active high, synchronous to clk_i |
| hb_i | input | 1 | Heartbeat from the processor, asynchronous |
| hb_float_i | input | 1 | High when the heartbeat pin is floating or three-stated |
| supply_ok_i | input | 1 | High while the supply is above threshold |
| wd_fault_no | output | 1 | Active-low watchdog fault |

## Verification
The bench builds the block with `TIMEOUT_TICKS` = 20 and `SYNC_STAGES` = 2. With these values a full timeout, the sticky fault and the point where a kick just arrives in time all fall within a few dozen cycles. This lets thousands of random heartbeat gaps each end either in a trip or in a restart. The edge-exact R3 window and the R8 check that a supply dip does not shift the trip cycle both depend on the short period, since the bench can count every cycle of it.

// File: rtl/hbwd_pkg.sv
package hbwd_pkg;

  typedef enum logic [1:0] {
    WD_IDLE = 2'd0,
    WD_RUN  = 2'd1,
    WD_TRIP = 2'd2
  } wd_state_e;

  function automatic int unsigned cnt_width(input int unsigned ticks);
    return (ticks < 2) ? 1 : $clog2(ticks + 1);
  endfunction

endpackage

// File: rtl/hbwd_sync.sv
module hbwd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[g] <= 1'b0;
          else         chain_q[g] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[g] <= 1'b0;
          else         chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/hbwd_edge.sv
module hbwd_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hb_i,
  output logic edge_o
);

  // primed once every sync stage and the history flop hold real samples
  localparam int unsigned FILL_MAX = STAGES + 1;
  localparam int unsigned FILL_W   = $clog2(FILL_MAX + 1);

  logic              hb_s;
  logic              hb_q;
  logic [FILL_W-1:0] fill_q;
  logic              primed;

  hbwd_sync #(.STAGES(STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (hb_i),
    .q_o   (hb_s)
  );

  assign primed = (fill_q == FILL_W'(FILL_MAX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hb_q   <= 1'b0;
      fill_q <= '0;
    end else begin
      hb_q <= hb_s;
      if (!primed) fill_q <= fill_q + 1'b1;
    end
  end

  assign edge_o = primed & (hb_s ^ hb_q);

  AST_FILL_MONO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed |=> primed); // R1

endmodule

// File: rtl/hbwd_timer.sv
module hbwd_timer
  import hbwd_pkg::*;
#(
  parameter int unsigned TIMEOUT_TICKS = 1600000
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      clr_i,
  input  logic      kick_i,
  output wd_state_e state_o
);

  localparam int unsigned CNT_W = cnt_width(TIMEOUT_TICKS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_TICKS - 1);

  wd_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WD_IDLE;
      cnt_q   <= '0;
    end else if (clr_i) begin
      state_q <= WD_IDLE;
      cnt_q   <= '0;
    end else if (kick_i) begin
      state_q <= WD_RUN;
      cnt_q   <= '0;
    end else if (state_q == WD_RUN) begin
      if (cnt_q == LAST) begin
        state_q <= WD_TRIP;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign state_o = state_q;

  AST_KICK_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i && !clr_i |=> state_q == WD_RUN && cnt_q == '0); // R4
  AST_IDLE_WAITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == WD_IDLE && !kick_i |=> state_q == WD_IDLE); // R2
  AST_TRIP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == WD_TRIP && !clr_i && !kick_i |=> state_q == WD_TRIP); // R7
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == WD_RUN |-> cnt_q <= LAST); // R3
  AST_TRIP_AT_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == WD_RUN && cnt_q == LAST && !clr_i && !kick_i |=> state_q == WD_TRIP); // R3
  AST_RUN_ADVANCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == WD_RUN && cnt_q != LAST && !clr_i && !kick_i |=> cnt_q == $past(cnt_q) + 1'b1); // R3

endmodule

// File: rtl/hb_watchdog.sv
module hb_watchdog
  import hbwd_pkg::*;
#(
  parameter int unsigned TIMEOUT_TICKS = 1600000,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sys_rst_i,
  input  logic hb_i,
  input  logic hb_float_i,
  input  logic supply_ok_i,
  output logic wd_fault_no
);

  logic      kick;
  logic      hold_clr;
  wd_state_e wd_state;

  hbwd_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .hb_i  (hb_i),
    .edge_o(kick)
  );

  assign hold_clr = sys_rst_i | hb_float_i;

  hbwd_timer #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (hold_clr),
    .kick_i (kick),
    .state_o(wd_state)
  );

  // supply loss bypasses all registers
  assign wd_fault_no = supply_ok_i & (wd_state != WD_TRIP);

  AST_SYSRST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_i |=> wd_state == WD_IDLE); // R5
  AST_FLOAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hb_float_i |=> wd_state == WD_IDLE); // R6
  AST_HOLD_DISCARDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_clr && kick |=> wd_state == WD_IDLE); // R9
  AST_SUPPLY_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |-> !wd_fault_no); // R8
  AST_SUPPLY_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    supply_ok_i && wd_state != WD_TRIP |-> wd_fault_no); // R8

endmodule

// File: tb/hb_watchdog_tb.sv
module hb_watchdog_tb;

  localparam int CLK_PERIOD = 10;
  localparam int T          = 20;
  localparam int STG        = 2;

  logic clk = 1'b0, rst_n = 1'b0, sys_rst = 1'b0, hb = 1'b0, flt = 1'b0, sup = 1'b1;
  logic fault_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  hb_watchdog #(.TIMEOUT_TICKS(T), .SYNC_STAGES(STG)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sys_rst_i(sys_rst), .hb_i(hb),
    .hb_float_i(flt), .supply_ok_i(sup), .wd_fault_no(fault_n)
  );

  int    checks = 0, fails = 0;
  string cur_req = "R1";

  // reference model built from R1-style rules: STG sync samples, one history sample
  logic [STG:0] m_pipe;
  int m_fill, m_state, m_cnt;
  bit m_edge;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pipe = '0; m_fill = 0; m_state = 0; m_cnt = 0;
    end else begin
      m_edge = (m_fill == STG + 1) && (m_pipe[STG-1] != m_pipe[STG]);
      if (sys_rst || flt) begin m_state = 0; m_cnt = 0; end
      else if (m_edge)    begin m_state = 1; m_cnt = 0; end
      else if (m_state == 1) begin
        m_cnt++;
        if (m_cnt == T) begin m_state = 2; m_cnt = 0; end
      end
      m_pipe = {m_pipe[STG-1:0], hb};
      if (m_fill < STG + 1) m_fill++;
    end
  end

  function automatic logic exp_fault(input logic s, input int st);
    return s && (st != 2);
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: wd_fault_no=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    chk(cur_req, fault_n, exp_fault(sup, m_state));
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'd24680));
    hb = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", fault_n, 1'b1);
    rst_n = 1'b1;
    cur_req = "R1";
    repeat (3*T) cyc();
    chk("R1", fault_n, 1'b1);
    chk("R2", fault_n, 1'b1);

    // R9: transitions during system reset are discarded
    cur_req = "R9";
    sys_rst = 1'b1; cyc(); hb = ~hb; cyc(); cyc(); hb = ~hb;
    repeat (3) cyc();
    sys_rst = 1'b0;
    repeat (3*T) cyc();
    chk("R9", fault_n, 1'b1);
    flt = 1'b1; cyc(); hb = ~hb;
    repeat (3) cyc();
    flt = 1'b0;
    repeat (3*T) cyc();
    chk("R9", fault_n, 1'b1);

    // R3: exact trip cycle
    cur_req = "R3";
    hb = ~hb;
    repeat (T+2) cyc();
    chk("R3", fault_n, 1'b1);
    cyc();
    chk("R3", fault_n, 1'b0);

    // R7: sticky until a transition
    cur_req = "R7";
    repeat (2*T) cyc();
    chk("R7", fault_n, 1'b0);
    hb = ~hb;
    repeat (2) cyc();
    chk("R7", fault_n, 1'b0);
    cyc();
    chk("R7", fault_n, 1'b1);

    // R4: both polarities keep it alive, last one restarts full count
    cur_req = "R4";
    for (int k = 0; k < 6; k++) begin
      hb = ~hb;
      repeat (T-3) cyc();
      chk("R4", fault_n, 1'b1);
    end
    hb = ~hb;
    repeat (T+2) cyc();
    chk("R4", fault_n, 1'b1);
    cyc();
    chk("R4", fault_n, 1'b0);

    // R5: system reset clears trip and holds
    cur_req = "R5";
    sys_rst = 1'b1; cyc();
    chk("R5", fault_n, 1'b1);
    repeat (2*T) cyc();
    sys_rst = 1'b0;
    repeat (3*T) cyc();
    chk("R5", fault_n, 1'b1);
    hb = ~hb;
    repeat (T/2) cyc();
    sys_rst = 1'b1; repeat (3) cyc(); sys_rst = 1'b0;
    repeat (2*T) cyc();
    chk("R5", fault_n, 1'b1);

    // R6: floating pin clears trip and holds
    cur_req = "R6";
    hb = ~hb;
    repeat (T+5) cyc();
    chk("R6", fault_n, 1'b0);
    flt = 1'b1; cyc();
    chk("R6", fault_n, 1'b1);
    for (int k = 0; k < 5; k++) begin hb = ~hb; repeat (2) cyc(); end
    repeat (3) cyc();
    flt = 1'b0;
    repeat (3*T) cyc();
    chk("R6", fault_n, 1'b1);

    // R8: supply dip is immediate and leaves the countdown intact
    cur_req = "R8";
    hb = ~hb;
    repeat (5) cyc();
    sup = 1'b0; #1;
    chk("R8", fault_n, 1'b0);
    cyc();
    sup = 1'b1; #1;
    chk("R8", fault_n, 1'b1);
    repeat (T-4) cyc();
    chk("R8", fault_n, 1'b1);
    cyc();
    chk("R8", fault_n, 1'b0);
    sup = 1'b0; #1;
    chk("R8", fault_n, 1'b0);
    sup = 1'b1; #1;
    chk("R8", fault_n, 1'b0);

    // random traffic against the model
    cur_req = "R3";
    for (int i = 0; i < 3000; i++) begin
      int unsigned r;
      r = $urandom_range(99);
      sys_rst = 1'b0; flt = 1'b0; sup = 1'b1;
      if ((i % 250) >= 30) begin
        if (r < 7)       hb = ~hb;
        else if (r == 7) sys_rst = 1'b1;
        else if (r == 8) flt = 1'b1;
        else if (r == 9) sup = 1'b0;
      end
      cyc();
    end
    finish_run();
  end

endmodule